// File: doc/BRIEF.md
# Receiver Watchdog and Interrupt Status

This block holds the eight-bit interrupt status of one serial channel. It merges seven sources into that status. Four are sticky events: an I/O pin change, address recognition, an Xon/Xoff event and a break change. The receive-inactivity watchdog is a fifth sticky bit. Two bits are live levels: receiver ready, computed from the receive FIFO fill level, and transmitter ready. An eight-bit mask register gates the status into a single interrupt request.

Each sticky bit has its own clear action. The break bit and the address bit clear on their own channel commands. The I/O bit clears when the input port is read. The flow-control bit clears when the flow-control status is read. The watchdog bit clears on any push into the receive FIFO or any host read of it.

The watchdog counts bit-time ticks while the FIFO holds data. It fires once more than 64 bit times have passed with no FIFO activity. A mode input chooses whether the status read-back is raw or ANDed with the mask.

Top module: `rx_irq_status`

## Requirements
- R1: A synchronous reset clears all status bits, the mask, the read-back `isr_view` and `irq` to zero.
- R2: `irq` is 1 exactly when some status bit and the matching mask bit are both 1. It follows the same clock edge that updates the status and mask.
- R3: With `masked_read_mode` 0, `isr_view` shows the raw status. With `masked_read_mode` 1, it shows the status ANDed with the mask.
- R4: Status bit positions are: 7 I/O change, 6 watchdog, 5 address recognized, 4 Xon/Xoff, 3 always 0, 2 break change, 1 receiver ready, 0 transmitter ready.
- R5: The break bit (bit 2) is set by `break_edge_evt`, which pulses at both the start and the end of a break. It clears only on command code 5'b00101, and a set in the same cycle wins over the clear.
- R6: The address bit (bit 5) clears on command 5'b11011. The I/O bit (bit 7) clears on `rd_ipr`. The Xon/Xoff bit (bit 4) clears on `rd_flow_status`. In each case a set in the same cycle wins.
- R7: The receiver-ready bit (bit 1) tracks `fifo_level` every cycle against `rx_level_sel`. The codes are: 00 means at least 1 entry, 01 at least 8, 10 at least 12, and 11 all 16. At the full setting, the bit clears when the level drops below 16 and sets again when the FIFO refills.
- R8: The watchdog bit (bit 6) sets on the 65th `bit_tick` counted while the FIFO is non-empty and no push or read has occurred.
- R9: A `fifo_push` or `fifo_read` clears the watchdog bit and restarts the count from zero. The count is held at zero while the FIFO is empty.
- R10: The transmitter-ready bit (bit 0) follows `tx_ready` each cycle.
- R11: `mask_wr` loads `mask_data` into the mask, and the new mask takes effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per receiver bit time |
| io_change_evt | input | 1 | I/O pin change pulse |
| addr_match_evt | input | 1 | Address recognized pulse |
| xon_xoff_evt | input | 1 | Xon/Xoff received pulse |
| break_edge_evt | input | 1 | Break start or end pulse |
| tx_ready | input | 1 | Transmitter ready level |
| fifo_level | input | LVL_W | Receive FIFO fill count |
| fifo_push | input | 1 | Character pushed into receive FIFO |
| fifo_read | input | 1 | Host read of receive FIFO |
| cmd_valid | input | 1 | Channel command strobe |
| cmd_code | input | 5 | Channel command code |
| rd_ipr | input | 1 | Input port read strobe |
| rd_flow_status | input | 1 | Flow-control status read strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 8 | Mask write data |
| masked_read_mode | input | 1 | 1: read-back is ANDed with mask |
| rx_level_sel | input | 2 | Receiver-ready threshold select |
| isr_view | output | 8 | Registered status read-back |
| irq | output | 1 | Registered interrupt request |

## Verification
The vectors fire a set and its clear in the same cycle for the break and I/O bits. A design that gives priority to the clear would drop an event that arrived during the host's clear.

The receiver-ready level is driven one entry below and exactly at each threshold. The full setting is also taken down and back up. An off-by-one compare would show up at those boundaries, as would a ready bit that latches instead of tracking the level.

The watchdog is stepped to 64 ticks and then to 65. It is then restarted by a push in the middle of a count, and starved with an empty FIFO. A counter that fires one tick early, keeps counting after an event or runs while the FIFO is empty would report the time-out at the wrong tick.

The masked read mode is checked against raw mode under the same status, which catches a read-back that ignores the mode or the mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ISR_W   = 8;
  localparam int unsigned BIT_IO  = 7;
  localparam int unsigned BIT_WD  = 6;
  localparam int unsigned BIT_ADR = 5;
  localparam int unsigned BIT_XON = 4;
  localparam int unsigned BIT_RSV = 3;
  localparam int unsigned BIT_BRK = 2;
  localparam int unsigned BIT_RXR = 1;
  localparam int unsigned BIT_TXR = 0;

  localparam logic [4:0] CMD_CLR_BRK = 5'b00101;
  localparam logic [4:0] CMD_CLR_ADR = 5'b11011;

  typedef enum logic [1:0] {
    LVL_ANY  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_3Q   = 2'b10,
    LVL_FULL = 2'b11
  } rx_lvl_e;
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic d_o,
  output logic q_o
);
  // set has priority so an event arriving during a clear is kept
  always_comb d_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/irq_wdog.sv
module irq_wdog #(
  parameter int WDOG_BITS = 64,
  parameter int LVL_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_push,
  input  logic             fifo_read,
  output logic             expire_o
);
  localparam int CNT_W = $clog2(WDOG_BITS + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WDOG_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic             fifo_empty, fifo_evt;

  always_comb begin
    fifo_empty = (fifo_level == '0);
    fifo_evt   = fifo_push | fifo_read;
    expire_o   = bit_tick & ~fifo_evt & ~fifo_empty & (cnt_q == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst || fifo_evt || fifo_empty) cnt_q <= '0;
    else if (bit_tick && cnt_q <= LIMIT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_rxlvl.sv
module irq_rxlvl
  import irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       rx_level_sel,
  output logic             ready_o
);
  localparam logic [LVL_W-1:0] TH_ANY  = LVL_W'(1);
  localparam logic [LVL_W-1:0] TH_HALF = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] TH_3Q   = LVL_W'((FIFO_DEPTH * 3) / 4);
  localparam logic [LVL_W-1:0] TH_FULL = LVL_W'(FIFO_DEPTH);

  always_comb begin
    unique case (rx_lvl_e'(rx_level_sel))
      LVL_ANY:  ready_o = (fifo_level >= TH_ANY);
      LVL_HALF: ready_o = (fifo_level >= TH_HALF);
      LVL_3Q:   ready_o = (fifo_level >= TH_3Q);
      LVL_FULL: ready_o = (fifo_level >= TH_FULL);
      default:  ready_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
  import irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  parameter  int WDOG_BITS  = 64,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             io_change_evt,
  input  logic             addr_match_evt,
  input  logic             xon_xoff_evt,
  input  logic             break_edge_evt,
  input  logic             tx_ready,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_push,
  input  logic             fifo_read,
  input  logic             cmd_valid,
  input  logic [4:0]       cmd_code,
  input  logic             rd_ipr,
  input  logic             rd_flow_status,
  input  logic             mask_wr,
  input  logic [7:0]       mask_data,
  input  logic             masked_read_mode,
  input  logic [1:0]       rx_level_sel,
  output logic [7:0]       isr_view,
  output logic             irq
);
  localparam int N_STICKY = 5;
  localparam int unsigned STICKY_POS [N_STICKY] = '{BIT_IO, BIT_WD, BIT_ADR, BIT_XON, BIT_BRK};

  logic                wd_expire, rx_rdy;
  logic [N_STICKY-1:0] st_set, st_clr, st_d, st_q;
  logic [ISR_W-1:0]    status_d, mask_d, mask_q, view_q;
  logic                irq_q;

  irq_wdog #(.WDOG_BITS(WDOG_BITS), .LVL_W(LVL_W)) u_wdog (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .fifo_level(fifo_level),
    .fifo_push(fifo_push), .fifo_read(fifo_read), .expire_o(wd_expire));

  irq_rxlvl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rxlvl (
    .fifo_level(fifo_level), .rx_level_sel(rx_level_sel), .ready_o(rx_rdy));

  always_comb begin
    st_set = {break_edge_evt, xon_xoff_evt, addr_match_evt, wd_expire, io_change_evt};
    st_clr = {cmd_valid && (cmd_code == CMD_CLR_BRK),
              rd_flow_status,
              cmd_valid && (cmd_code == CMD_CLR_ADR),
              fifo_push | fifo_read,
              rd_ipr};
  end

  for (genvar gi = 0; gi < N_STICKY; gi++) begin : g_sticky
    irq_sticky u_bit (
      .clk(clk), .rst(rst), .set_i(st_set[gi]), .clr_i(st_clr[gi]),
      .d_o(st_d[gi]), .q_o(st_q[gi]));
  end

  always_comb begin
    status_d = '0;
    for (int i = 0; i < N_STICKY; i++) status_d[STICKY_POS[i]] = st_d[i];
    status_d[BIT_RSV] = 1'b0;
    status_d[BIT_RXR] = rx_rdy;
    status_d[BIT_TXR] = tx_ready;
    mask_d = mask_wr ? mask_data : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      view_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(status_d & mask_d);
      view_q <= masked_read_mode ? (status_d & mask_d) : status_d;
    end
  end

  assign isr_view = view_q;
  assign irq      = irq_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       io_change_evt,
  input logic       break_edge_evt,
  input logic       tx_ready,
  input logic       fifo_push,
  input logic       fifo_read,
  input logic       cmd_valid,
  input logic [4:0] cmd_code,
  input logic       rd_ipr,
  input logic       masked_read_mode,
  input logic [7:0] isr_view,
  input logic       irq
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (isr_view == 8'h00 && !irq));
  // R4
  rsv_bit_zero_chk: assert property (@(posedge clk) disable iff (rst) isr_view[3] == 1'b0);
  // R2
  irq_matches_masked_view_chk: assert property (@(posedge clk) disable iff (rst)
    masked_read_mode |=> (irq == (|isr_view)));
  // R9
  wdog_cleared_by_fifo_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_push || fifo_read) |=> !isr_view[6]);
  // R5
  brk_clear_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 5'b00101 && !break_edge_evt) |=> !isr_view[2]);
  // R6
  io_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ipr && !io_change_evt) |=> !isr_view[7]);
  // R10
  tx_ready_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (!masked_read_mode && tx_ready) |=> isr_view[0]);
endmodule

bind rx_irq_status irq_status_chk u_irq_status_chk (
  .clk(clk), .rst(rst), .io_change_evt(io_change_evt), .break_edge_evt(break_edge_evt),
  .tx_ready(tx_ready), .fifo_push(fifo_push), .fifo_read(fifo_read),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rd_ipr(rd_ipr),
  .masked_read_mode(masked_read_mode), .isr_view(isr_view), .irq(irq));

// File: tb/test_rx_irq_status.sv
module test_rx_irq_status;
  localparam int PERIOD = 10;
  localparam int NV     = 27;

  logic       clk = 0, rst = 1;
  logic       bit_tick = 0, io_change_evt = 0, addr_match_evt = 0, xon_xoff_evt = 0;
  logic       break_edge_evt = 0, tx_ready = 0, fifo_push = 0, fifo_read = 0;
  logic       cmd_valid = 0, rd_ipr = 0, rd_flow_status = 0, mask_wr = 0, masked_read_mode = 0;
  logic [4:0] cmd_code = 0, fifo_level = 0;
  logic [7:0] mask_data = 0, isr_view;
  logic [1:0] rx_level_sel = 0;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_irq_status i_rx_irq_status (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .io_change_evt(io_change_evt),
    .addr_match_evt(addr_match_evt), .xon_xoff_evt(xon_xoff_evt),
    .break_edge_evt(break_edge_evt), .tx_ready(tx_ready), .fifo_level(fifo_level),
    .fifo_push(fifo_push), .fifo_read(fifo_read), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .rd_ipr(rd_ipr), .rd_flow_status(rd_flow_status),
    .mask_wr(mask_wr), .mask_data(mask_data), .masked_read_mode(masked_read_mode),
    .rx_level_sel(rx_level_sel), .isr_view(isr_view), .irq(irq));

  // {ev io,adr,xon,brk}{clr io,adr,xon,brk} lvl sel tx mwr mdata mode | view irq
  localparam logic [34:0] VEC [NV] = '{
    {4'b0000,4'b0000,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R1 quiet
    {4'b0000,4'b0000,5'd0, 2'd0,1'b1,1'b0,8'h00,1'b0, 8'h01,1'b0}, // R10
    {4'b0000,4'b0000,5'd0, 2'd0,1'b1,1'b1,8'h01,1'b0, 8'h01,1'b1}, // R11 R2
    {4'b1000,4'b0000,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h80,1'b0}, // R4
    {4'b0001,4'b0000,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h86,1'b0}, // R5 R7
    {4'b0000,4'b0000,5'd1, 2'd0,1'b0,1'b1,8'h04,1'b0, 8'h86,1'b1}, // R2
    {4'b0000,4'b0000,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b1, 8'h04,1'b1}, // R3
    {4'b0000,4'b0001,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b1, 8'h00,1'b0}, // R5 clear
    {4'b0110,4'b0000,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'hB2,1'b0}, // R4
    {4'b0000,4'b0000,5'd1, 2'd0,1'b0,1'b1,8'hFF,1'b0, 8'hB2,1'b1}, // R2
    {4'b0000,4'b1000,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h32,1'b1}, // R6 io
    {4'b0000,4'b0100,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h12,1'b1}, // R6 adr
    {4'b0000,4'b0010,5'd1, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h02,1'b1}, // R6 xon
    {4'b0000,4'b0000,5'd7, 2'd1,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R7
    {4'b0000,4'b0000,5'd8, 2'd1,1'b0,1'b0,8'h00,1'b0, 8'h02,1'b1}, // R7
    {4'b0000,4'b0000,5'd11,2'd2,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R7
    {4'b0000,4'b0000,5'd12,2'd2,1'b0,1'b0,8'h00,1'b0, 8'h02,1'b1}, // R7
    {4'b0000,4'b0000,5'd15,2'd3,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R7
    {4'b0000,4'b0000,5'd16,2'd3,1'b0,1'b0,8'h00,1'b0, 8'h02,1'b1}, // R7
    {4'b0000,4'b0000,5'd15,2'd3,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R7
    {4'b0000,4'b0000,5'd16,2'd3,1'b0,1'b0,8'h00,1'b0, 8'h02,1'b1}, // R7
    {4'b0001,4'b0001,5'd16,2'd3,1'b0,1'b0,8'h00,1'b0, 8'h06,1'b1}, // R5 set wins
    {4'b0000,4'b0001,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}, // R5
    {4'b1000,4'b0000,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b1, 8'h80,1'b1}, // R3
    {4'b0000,4'b1000,5'd0, 2'd0,1'b0,1'b1,8'h00,1'b1, 8'h00,1'b0}, // R11
    {4'b1000,4'b1000,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h80,1'b0}, // R6 set wins
    {4'b0000,4'b1000,5'd0, 2'd0,1'b0,1'b0,8'h00,1'b0, 8'h00,1'b0}  // R6
  };

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: view/irq got %h/%b expected %h/%b", req, got[8:1], got[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1; cyc();
    end
    bit_tick = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    chk("R1", {isr_view, irq}, 9'h000);

    for (int v = 0; v < NV; v++) begin
      {io_change_evt, addr_match_evt, xon_xoff_evt, break_edge_evt} = VEC[v][34:31];
      rd_ipr         = VEC[v][30];
      rd_flow_status = VEC[v][28];
      cmd_valid      = VEC[v][29] | VEC[v][27];
      cmd_code       = VEC[v][29] ? 5'b11011 : (VEC[v][27] ? 5'b00101 : 5'b00000);
      fifo_level     = VEC[v][26:22];
      rx_level_sel   = VEC[v][21:20];
      tx_ready       = VEC[v][19];
      mask_wr        = VEC[v][18];
      mask_data      = VEC[v][17:10];
      masked_read_mode = VEC[v][9];
      cyc();
      chk($sformatf("vector %0d", v), {isr_view, irq}, VEC[v][8:0]);
    end
    {io_change_evt, addr_match_evt, xon_xoff_evt, break_edge_evt} = '0;
    {rd_ipr, rd_flow_status, cmd_valid, mask_wr, masked_read_mode} = '0;
    cmd_code = '0;

    // R1: reset mid-run drops pending bits and the mask
    io_change_evt = 1; mask_wr = 1; mask_data = 8'hFF; cyc();
    io_change_evt = 0; mask_wr = 0; rst = 1; cyc();
    rst = 0; tx_ready = 1; masked_read_mode = 1; cyc();
    chk("R1 mask cleared", {isr_view, irq}, 9'h000);
    tx_ready = 0; masked_read_mode = 0;

    // R8/R9 watchdog
    mask_wr = 1; mask_data = 8'h40; fifo_level = 5'd3; rx_level_sel = 2'd0; cyc();
    mask_wr = 0; fifo_push = 1; cyc(); fifo_push = 0;
    ticks(64);
    chk_bit("R8 no expiry at 64 ticks", isr_view[6], 1'b0);
    ticks(1);
    chk_bit("R8 expiry at 65th tick", isr_view[6], 1'b1);
    chk_bit("R8 irq on time-out", irq, 1'b1);
    fifo_read = 1; cyc(); fifo_read = 0;
    chk_bit("R9 read clears", isr_view[6], 1'b0);
    chk_bit("R9 irq drops", irq, 1'b0);
    fifo_level = 5'd0;
    ticks(100);
    chk_bit("R9 empty holds", isr_view[6], 1'b0);
    fifo_level = 5'd3;
    ticks(64);
    chk_bit("R9 count from zero after empty", isr_view[6], 1'b0);
    ticks(1);
    chk_bit("R9 expiry after empty", isr_view[6], 1'b1);
    fifo_read = 1; cyc(); fifo_read = 0;
    ticks(40);
    fifo_push = 1; cyc(); fifo_push = 0;
    chk_bit("R9 push clears", isr_view[6], 1'b0);
    ticks(64);
    chk_bit("R9 push restarts count", isr_view[6], 1'b0);
    ticks(1);
    chk_bit("R9 expiry after restart", isr_view[6], 1'b1);
    fifo_push = 1; cyc(); fifo_push = 0;
    chk_bit("R9 push clears again", isr_view[6], 1'b0);

    report();
  end
endmodule